// File: doc/BRIEF.md
# NAND Flash Cycle Engine

This block sits between a 16-bit host register port and a raw 8-bit NAND flash device. The host loads a command byte, an address byte and a buffer selection, then writes a single trigger bit. The engine then performs exactly one bus operation on the flash pins: a command latch, an address latch, a page program from an internal buffer, a page read into an internal buffer, an identifier read or a status read. It generates the latch enables, the write and read strobes, the chip enables and the data bus timing itself.

The flash ready/busy line goes through a two-flop synchronizer and is handled inside the engine. A page program or a page read does not report completion until the device has become ready again. Each finished operation sets a sticky done flag that only the host can clear. An interrupt line reflects that flag unless a mask bit blocks it. A self-clearing soft-reset bit aborts any operation in progress.

The internal page storage holds `BUF_COUNT` buffers of `PAGE_LEN` bytes each. The host reads and writes it through the upper half of the host address space.

Top module: `nand_cycle_engine`

## Requirements
- R1: Trigger register (offset 3) bits 0..5 start, in order, command, address, page program, page read, ID read and status read. When several bits are written together, only the lowest set bit starts an operation.
- R2: A command operation drives the low byte of the command register (offset 0) on the data bus with CLE high and ALE low. It gives exactly one WE# low pulse of `LOW_W` cycles, and CLE, ALE and the data stay unchanged while WE# is low.
- R3: An address operation drives the low byte of the address register (offset 1), with ALE high for the whole WE# low pulse.
- R4: A page program sends `PAGE_LEN` bytes, in order from byte 0, out of the buffer chosen by bits [2:0] of the buffer register (offset 2). One WE# pulse is used per byte.
- R5: A page read gives `PAGE_LEN` RE# pulses of `LOW_W` low cycles. It stores the byte present at the end of each low phase into successive locations of the selected buffer.
- R6: An ID read captures `ID_LEN` bytes into bytes 0.. of the selected buffer. A status read captures one byte into byte 0.
- R7: A page program or page read sets done only after the synchronized ready/busy input has been high for at least two cycles.
- R8: Bit 15 of the trigger register is set when an operation finishes. A trigger write with bit 15 at 0 clears it. A write with bit 15 at 1 leaves it unchanged.
- R9: The `irq` output equals done AND NOT the mask bit (configuration register offset 4, bit 4).
- R10: A trigger written while an operation or a soft reset is running starts nothing. While an operation runs, trigger bits 0..5 read back as the one-hot code of that operation.
- R11: Writing 1 to configuration bit 6 aborts the current operation, returns all strobes to idle, and reads back as 1. The bit clears itself after `RESET_CYC` cycles.
- R12: With configuration bit 7 set, exactly the chip enable chosen by buffer-register bits [6:5] is driven low. With bit 7 clear, all four are high.
- R13: After reset, all registers read 0, `irq` is 0, all chip enables and WE#/RE# are high, and CLE/ALE are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | HAW | Host address; MSB=1 selects buffer RAM, else low 3 bits pick a register |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe; data valid the next cycle |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| irq | output | 1 | Completion interrupt |
| fl_ce_n | output | 4 | Active-low chip enables |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Data bus out |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_i | input | 8 | Data bus in |
| fl_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The bench builds the engine with `PAGE_LEN=8`, `ID_LEN=4`, `LOW_W=2`, `HIGH_W=1`, `WB_CYC=3` and `RESET_CYC=10`, keeping all eight buffers. With pages this short, every buffer can be swept by a page read, and programs from several buffers can be compared byte for byte against a behavioural device. The short reset count lets the self-clearing bit be observed both set and cleared by polling. A device busy time of 20 cycles is long enough to place trigger writes and a soft reset inside a running operation.

// File: rtl/nce_pkg.sv
package nce_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_CMD, OP_ADDR, OP_PROG, OP_READ, OP_ID, OP_STAT
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_FETCH, S_LOAD, S_WE_LO, S_WE_HI,
    S_WB, S_WAIT, S_RE_LO, S_RE_HI, S_DONE
  } state_e;

  localparam logic [2:0] REG_CMD    = 3'd0;
  localparam logic [2:0] REG_ADDR   = 3'd1;
  localparam logic [2:0] REG_BUFSEL = 3'd2;
  localparam logic [2:0] REG_TRIG   = 3'd3;
  localparam logic [2:0] REG_CFG    = 3'd4;

  localparam int DONE_BIT = 15;
  localparam int MASK_BIT = 4;
  localparam int SRST_BIT = 6;
  localparam int CE_BIT   = 7;

  // lowest set trigger bit wins
  function automatic op_e pick_op(input logic [5:0] b);
    if (b[0])      return OP_CMD;
    else if (b[1]) return OP_ADDR;
    else if (b[2]) return OP_PROG;
    else if (b[3]) return OP_READ;
    else if (b[4]) return OP_ID;
    else if (b[5]) return OP_STAT;
    else           return OP_NONE;
  endfunction

  function automatic logic [5:0] op_code(input op_e op);
    case (op)
      OP_CMD:  return 6'b000001;
      OP_ADDR: return 6'b000010;
      OP_PROG: return 6'b000100;
      OP_READ: return 6'b001000;
      OP_ID:   return 6'b010000;
      OP_STAT: return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

endpackage

// File: rtl/nce_buf_ram.sv
module nce_buf_ram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/nce_regs.sv
module nce_regs
  import nce_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  sel,
  input  logic [15:0] wdata,
  input  logic        busy,
  input  logic        done_pulse,
  input  logic        rst_done,
  input  op_e         cur_op,
  output logic [7:0]  cmd_byte,
  output logic [7:0]  addr_byte,
  output logic [2:0]  buf_sel,
  output logic [1:0]  cs_sel,
  output logic        ce_en,
  output logic        irq_mask,
  output logic        srst,
  output logic        srst_kick,
  output logic        start,
  output op_e         start_op,
  output logic        done,
  output logic        irq,
  output logic [15:0] rd_val
);
  logic [15:0] addr_q;
  logic        trig_wr, cfg_wr, done_n, mask_n;

  assign trig_wr   = wr_en && (sel == REG_TRIG);
  assign cfg_wr    = wr_en && (sel == REG_CFG);
  assign srst_kick = cfg_wr && wdata[SRST_BIT];
  assign start     = trig_wr && (|wdata[5:0]) && !busy && !srst;
  assign start_op  = pick_op(wdata[5:0]);
  assign addr_byte = addr_q[7:0];

  always_comb begin
    done_n = done;
    if (trig_wr && !wdata[DONE_BIT]) done_n = 1'b0;
    if (done_pulse) done_n = 1'b1;
    mask_n = cfg_wr ? wdata[MASK_BIT] : irq_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_byte <= '0;
      addr_q   <= '0;
      buf_sel  <= '0;
      cs_sel   <= '0;
      ce_en    <= 1'b0;
      irq_mask <= 1'b0;
      srst     <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_en && sel == REG_CMD)  cmd_byte <= wdata[7:0];
      if (wr_en && sel == REG_ADDR) addr_q   <= wdata;
      if (wr_en && sel == REG_BUFSEL) begin
        buf_sel <= wdata[2:0];
        cs_sel  <= wdata[6:5];
      end
      if (rst_done) srst <= 1'b0;
      if (cfg_wr) begin
        ce_en    <= wdata[CE_BIT];
        irq_mask <= wdata[MASK_BIT];
        if (wdata[SRST_BIT]) srst <= 1'b1;
      end
      done <= done_n;
      irq  <= done_n && !mask_n;
    end
  end

  always_comb begin
    case (sel)
      REG_CMD:    rd_val = {8'h00, cmd_byte};
      REG_ADDR:   rd_val = addr_q;
      REG_BUFSEL: rd_val = {9'h000, cs_sel, 2'b00, buf_sel};
      REG_TRIG:   rd_val = {done, 9'h000, op_code(cur_op)};
      REG_CFG:    rd_val = {8'h00, ce_en, srst, 1'b0, irq_mask, 4'h0};
      default:    rd_val = 16'h0000;
    endcase
  end
endmodule

// File: rtl/nce_seq.sv
module nce_seq
  import nce_pkg::*;
#(
  parameter int PAGE_LEN  = 16,
  parameter int ID_LEN    = 4,
  parameter int BSW       = 3,
  parameter int LOW_W     = 2,
  parameter int HIGH_W    = 2,
  parameter int WB_CYC    = 4,
  parameter int RESET_CYC = 16,
  localparam int IDX_W = $clog2(PAGE_LEN),
  localparam int RAW   = BSW + IDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  op_e            start_op,
  input  logic           srst_kick,
  input  logic [7:0]     cmd_byte,
  input  logic [7:0]     addr_byte,
  input  logic [BSW-1:0] buf_sel,
  input  logic           rb_n,
  input  logic [7:0]     dq_i,
  input  logic [7:0]     ram_rdata,
  output logic [RAW-1:0] ram_addr,
  output logic           ram_we,
  output logic [7:0]     ram_wdata,
  output logic           cle,
  output logic           ale,
  output logic           we_n,
  output logic           re_n,
  output logic [7:0]     dq_o,
  output logic           dq_oe,
  output logic           busy,
  output op_e            cur_op,
  output logic           done_pulse,
  output logic           rst_done
);
  localparam int CMAX = (RESET_CYC > WB_CYC) ?
                        ((RESET_CYC > LOW_W) ? ((RESET_CYC > HIGH_W) ? RESET_CYC : HIGH_W)
                                             : ((LOW_W > HIGH_W) ? LOW_W : HIGH_W)) :
                        ((WB_CYC > LOW_W) ? ((WB_CYC > HIGH_W) ? WB_CYC : HIGH_W)
                                          : ((LOW_W > HIGH_W) ? LOW_W : HIGH_W));
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0]    LOW_LAST  = CW'(LOW_W - 1);
  localparam logic [CW-1:0]    HIGH_LAST = CW'(HIGH_W - 1);
  localparam logic [CW-1:0]    WB_LAST   = CW'(WB_CYC - 1);
  localparam logic [CW-1:0]    RST_LAST  = CW'(RESET_CYC - 1);
  localparam logic [IDX_W-1:0] PAGE_LAST = IDX_W'(PAGE_LEN - 1);
  localparam logic [IDX_W-1:0] ID_LAST   = IDX_W'(ID_LEN - 1);

  state_e           state;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] idx, last_idx;
  logic [1:0]       rb_s;

  always_comb begin
    case (cur_op)
      OP_READ: last_idx = PAGE_LAST;
      OP_ID:   last_idx = ID_LAST;
      default: last_idx = '0;
    endcase
  end

  assign ram_addr   = {buf_sel, idx};
  assign ram_we     = (state == S_RE_LO) && (cnt == LOW_LAST) && !srst_kick;
  assign ram_wdata  = dq_i;
  assign busy       = (state != S_IDLE);
  assign done_pulse = (state == S_DONE);
  assign rst_done   = (state == S_RST) && (cnt == RST_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cur_op <= OP_NONE;
      cnt    <= '0;
      idx    <= '0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
      rb_s   <= 2'b00;
    end else begin
      rb_s <= {rb_s[0], rb_n};
      if (srst_kick) begin
        state  <= S_RST;
        cur_op <= OP_NONE;
        cnt    <= '0;
        cle    <= 1'b0;
        ale    <= 1'b0;
        we_n   <= 1'b1;
        re_n   <= 1'b1;
        dq_oe  <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            cur_op <= start_op;
            cnt    <= '0;
            idx    <= '0;
            case (start_op)
              OP_CMD: begin
                cle <= 1'b1; dq_o <= cmd_byte; dq_oe <= 1'b1; we_n <= 1'b0; state <= S_WE_LO;
              end
              OP_ADDR: begin
                ale <= 1'b1; dq_o <= addr_byte; dq_oe <= 1'b1; we_n <= 1'b0; state <= S_WE_LO;
              end
              OP_PROG: state <= S_FETCH;
              OP_READ: state <= S_WB;
              default: begin
                re_n <= 1'b0; state <= S_RE_LO;
              end
            endcase
          end
          S_RST: begin
            if (cnt == RST_LAST) begin
              state <= S_IDLE; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_FETCH: state <= S_LOAD;
          S_LOAD: begin
            dq_o <= ram_rdata; dq_oe <= 1'b1; we_n <= 1'b0; state <= S_WE_LO;
          end
          S_WE_LO: begin
            if (cnt == LOW_LAST) begin
              we_n <= 1'b1; cnt <= '0; state <= S_WE_HI;
            end else cnt <= cnt + 1'b1;
          end
          S_WE_HI: begin
            if (cnt == HIGH_LAST) begin
              cnt   <= '0;
              cle   <= 1'b0;
              ale   <= 1'b0;
              dq_oe <= 1'b0;
              if (cur_op == OP_PROG && idx != PAGE_LAST) begin
                idx <= idx + 1'b1; state <= S_FETCH;
              end else if (cur_op == OP_PROG) state <= S_WB;
              else state <= S_DONE;
            end else cnt <= cnt + 1'b1;
          end
          S_WB: begin
            if (cnt == WB_LAST) begin
              cnt <= '0; state <= S_WAIT;
            end else cnt <= cnt + 1'b1;
          end
          S_WAIT: if (rb_s[1]) begin
            if (cur_op == OP_READ) begin
              idx <= '0; re_n <= 1'b0; state <= S_RE_LO;
            end else state <= S_DONE;
          end
          S_RE_LO: begin
            if (cnt == LOW_LAST) begin
              re_n <= 1'b1; cnt <= '0; state <= S_RE_HI;
            end else cnt <= cnt + 1'b1;
          end
          S_RE_HI: begin
            if (cnt == HIGH_LAST) begin
              cnt <= '0;
              if (idx == last_idx) state <= S_DONE;
              else begin
                idx <= idx + 1'b1; re_n <= 1'b0; state <= S_RE_LO;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DONE: begin
            state <= S_IDLE; cur_op <= OP_NONE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nce_pkg::*;
#(
  parameter int BUF_COUNT = 8,
  parameter int PAGE_LEN  = 16,
  parameter int ID_LEN    = 4,
  parameter int LOW_W     = 2,
  parameter int HIGH_W    = 2,
  parameter int WB_CYC    = 4,
  parameter int RESET_CYC = 16,
  localparam int BSW       = $clog2(BUF_COUNT),
  localparam int IDX_W     = $clog2(PAGE_LEN),
  localparam int RAM_DEPTH = BUF_COUNT * PAGE_LEN,
  localparam int RAW       = BSW + IDX_W,
  localparam int HAW       = RAW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HAW-1:0] hst_addr,
  input  logic           hst_wr,
  input  logic           hst_rd,
  input  logic [15:0]    hst_wdata,
  output logic [15:0]    hst_rdata,
  output logic           irq,
  output logic [3:0]     fl_ce_n,
  output logic           fl_cle,
  output logic           fl_ale,
  output logic           fl_we_n,
  output logic           fl_re_n,
  output logic [7:0]     fl_dq_o,
  output logic           fl_dq_oe,
  input  logic [7:0]     fl_dq_i,
  input  logic           fl_rb_n
);
  logic           buf_region, reg_wr;
  logic [7:0]     cmd_byte, addr_byte, ram_a_rdata, ram_b_rdata, ram_b_wdata;
  logic [2:0]     buf_sel;
  logic [1:0]     cs_sel;
  logic           ce_en, irq_mask, srst, srst_kick, start, done_w;
  logic           busy, done_pulse, rst_done, ram_b_we;
  logic [RAW-1:0] ram_b_addr;
  logic [15:0]    reg_rd_val, reg_rd_q;
  logic           rd_buf_q;
  op_e            start_op, cur_op;

  assign buf_region = hst_addr[HAW-1];
  assign reg_wr     = hst_wr && !buf_region;

  nce_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(hst_addr[2:0]), .wdata(hst_wdata),
    .busy(busy), .done_pulse(done_pulse), .rst_done(rst_done), .cur_op(cur_op),
    .cmd_byte(cmd_byte), .addr_byte(addr_byte), .buf_sel(buf_sel), .cs_sel(cs_sel),
    .ce_en(ce_en), .irq_mask(irq_mask), .srst(srst), .srst_kick(srst_kick),
    .start(start), .start_op(start_op), .done(done_w), .irq(irq), .rd_val(reg_rd_val)
  );

  nce_seq #(
    .PAGE_LEN(PAGE_LEN), .ID_LEN(ID_LEN), .BSW(BSW), .LOW_W(LOW_W),
    .HIGH_W(HIGH_W), .WB_CYC(WB_CYC), .RESET_CYC(RESET_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op), .srst_kick(srst_kick),
    .cmd_byte(cmd_byte), .addr_byte(addr_byte), .buf_sel(buf_sel[BSW-1:0]),
    .rb_n(fl_rb_n), .dq_i(fl_dq_i), .ram_rdata(ram_b_rdata), .ram_addr(ram_b_addr),
    .ram_we(ram_b_we), .ram_wdata(ram_b_wdata), .cle(fl_cle), .ale(fl_ale),
    .we_n(fl_we_n), .re_n(fl_re_n), .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .busy(busy),
    .cur_op(cur_op), .done_pulse(done_pulse), .rst_done(rst_done)
  );

  nce_buf_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk),
    .a_addr(hst_addr[RAW-1:0]), .a_we(hst_wr && buf_region), .a_wdata(hst_wdata[7:0]),
    .a_rdata(ram_a_rdata),
    .b_addr(ram_b_addr), .b_we(ram_b_we), .b_wdata(ram_b_wdata), .b_rdata(ram_b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rd_buf_q <= 1'b0;
      fl_ce_n  <= 4'hF;
    end else begin
      if (hst_rd) begin
        reg_rd_q <= reg_rd_val;
        rd_buf_q <= buf_region;
      end
      fl_ce_n <= ce_en ? ~(4'b0001 << cs_sel) : 4'hF;
    end
  end

  assign hst_rdata = rd_buf_q ? {8'h00, ram_a_rdata} : reg_rd_q;
endmodule

// File: rtl/nce_checker.sv
module nce_checker #(
  parameter int HAW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [HAW-1:0] hst_addr,
  input logic           hst_wr,
  input logic [15:0]    hst_wdata,
  input logic           irq,
  input logic           done,
  input logic           mask,
  input logic           busy,
  input logic [3:0]     fl_ce_n,
  input logic           fl_cle,
  input logic           fl_ale,
  input logic           fl_we_n,
  input logic           fl_re_n,
  input logic [7:0]     fl_dq_o
);
  logic trig_clear;
  assign trig_clear = hst_wr && !hst_addr[HAW-1] && (hst_addr[2:0] == 3'd3) && !hst_wdata[15];

  assert_irq_follows_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (done && !mask));

  assert_no_latch_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));

  assert_bus_steady_in_we_R2: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_cle) && $stable(fl_ale) && $stable(fl_dq_o)));

  assert_no_strobe_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));

  assert_single_ce_R12: assert property (@(posedge clk) disable iff (rst)
    $countones(~fl_ce_n) <= 1);

  assert_done_cleared_by_host_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(trig_clear));

  assert_idle_pins_R13: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale));
endmodule

bind nand_cycle_engine nce_checker #(.HAW(HAW)) u_chk (
  .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
  .irq(irq), .done(done_w), .mask(irq_mask), .busy(busy), .fl_ce_n(fl_ce_n),
  .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o)
);

// File: tb/nand_cycle_engine_tb_top.sv
module nand_cycle_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_LEN = 8;
  localparam int ID_LEN   = 4;
  localparam int LOW_W    = 2;
  localparam int RST_CYC  = 10;
  localparam int BUSY     = 20;
  localparam int HAW      = 7;
  localparam logic [6:0] A_CMD = 7'd0, A_ADDR = 7'd1, A_BUF = 7'd2, A_TRIG = 7'd3, A_CFG = 7'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic [HAW-1:0] hst_addr = '0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [3:0] fl_ce_n;
  logic [7:0] fl_dq_o;
  logic [7:0] fl_dq_i = '0;
  logic fl_rb_n = 1'b1;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cycle_engine #(
    .BUF_COUNT(8), .PAGE_LEN(PAGE_LEN), .ID_LEN(ID_LEN), .LOW_W(LOW_W),
    .HIGH_W(1), .WB_CYC(3), .RESET_CYC(RST_CYC)
  ) dut_i (
    .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .fl_ce_n(fl_ce_n),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rb_n(fl_rb_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] page_byte(input logic [7:0] a, input int i);
    return 8'((int'(a) * 7 + i * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] id_byte(input int i);
    return 8'(8'h2C ^ (i * 17));
  endfunction

  // ---------------- behavioural flash device ----------------
  logic prev_we = 1'b1, prev_re = 1'b1, prev_irq = 1'b0;
  logic [7:0] last_cmd = '0, last_addr = '0;
  logic [7:0] prog_mem [PAGE_LEN];
  int cmd_cnt = 0, ale_cnt = 0, prog_cnt = 0, prog_total = 0;
  int rd_idx = 0, rd_mode = 0, busy_cnt = 0, rb_hi_run = 0;
  int we_run = 0, re_run = 0;
  logic cle_at_fall = 1'b0;
  logic chk_ready = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (busy_cnt > 0) busy_cnt--;
      if (prev_we && !fl_we_n) cle_at_fall = fl_cle;
      if (!fl_we_n) we_run++;
      if (!prev_we && fl_we_n) begin
        check("R2 we_low_width", we_run, LOW_W);
        check("R2 cle_held", int'(fl_cle), int'(cle_at_fall));
        we_run = 0;
        if (fl_cle) begin
          last_cmd = fl_dq_o; cmd_cnt++; rd_idx = 0;
          rd_mode = (fl_dq_o == 8'h90) ? 1 : (fl_dq_o == 8'h70) ? 2 : 0;
          if (fl_dq_o == 8'h80) prog_cnt = 0;
          if (fl_dq_o == 8'h30) busy_cnt = BUSY;
        end else if (fl_ale) begin
          last_addr = fl_dq_o; ale_cnt++;
        end else begin
          if (prog_cnt < PAGE_LEN) prog_mem[prog_cnt] = fl_dq_o;
          prog_cnt++; prog_total++;
          if (prog_cnt == PAGE_LEN) busy_cnt = BUSY;
        end
      end
      if (!fl_re_n) re_run++;
      if (prev_re && !fl_re_n)
        fl_dq_i = (rd_mode == 1) ? id_byte(rd_idx) : (rd_mode == 2) ? 8'hE0
                                                   : page_byte(last_addr, rd_idx);
      if (!prev_re && fl_re_n) begin
        check("R5 re_low_width", re_run, LOW_W);
        re_run = 0; rd_idx++;
      end
      fl_rb_n = (busy_cnt == 0);
      rb_hi_run = fl_rb_n ? rb_hi_run + 1 : 0;
      if (!prev_irq && irq && chk_ready)
        check("R7 done_after_ready", int'(rb_hi_run >= 2), 1);
      prev_we = fl_we_n; prev_re = fl_re_n; prev_irq = irq;
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk); hst_wr = 1'b0;
  endtask
  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_rd = 1'b1;
    @(negedge clk); hst_rd = 1'b0; d = hst_rdata;
  endtask
  task automatic wait_set();
    logic [15:0] v;
    for (int k = 0; k < 500; k++) begin
      rd(A_TRIG, v);
      if (v[15]) return;
    end
    check("done_timeout", 0, 1);
  endtask
  task automatic wait_done();
    wait_set();
    wr(A_TRIG, 16'h0000);
  endtask
  task automatic do_op(input logic [15:0] trig);
    wr(A_TRIG, trig); wait_done();
  endtask
  task automatic send_cmd(input logic [7:0] c);
    wr(A_CMD, {8'h00, c}); do_op(16'h0001);
  endtask
  task automatic send_addr(input logic [7:0] a);
    wr(A_ADDR, {8'h00, a}); do_op(16'h0002);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int c0, a0, p0, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    rd(A_TRIG, v); check("R13 trig_reset", v, 0);
    rd(A_CFG, v);  check("R13 cfg_reset", v, 0);
    rd(A_BUF, v);  check("R13 buf_reset", v, 0);
    check("R13 irq_reset", irq, 0);
    check("R13 ce_reset", fl_ce_n, 4'hF);
    check("R13 strobes_reset", {fl_we_n, fl_re_n, fl_cle, fl_ale}, 4'b1100);

    // R12 chip enable
    wr(A_BUF, 16'h0040); wr(A_CFG, 16'h0080); @(negedge clk);
    check("R12 ce_cs2", fl_ce_n, 4'b1011);
    wr(A_BUF, 16'h0060); @(negedge clk);
    check("R12 ce_cs3", fl_ce_n, 4'b0111);
    wr(A_CFG, 16'h0000); @(negedge clk);
    check("R12 ce_off", fl_ce_n, 4'hF);
    wr(A_CFG, 16'h0080);

    // R2 command cycle
    c0 = cmd_cnt;
    send_cmd(8'h90);
    check("R2 cmd_byte", last_cmd, 8'h90);
    check("R2 one_cmd", cmd_cnt, c0 + 1);

    // R3 address cycle: only low byte
    wr(A_ADDR, 16'h01A5); do_op(16'h0002);
    check("R3 addr_low_byte", last_addr, 8'hA5);

    // R6 ID read into buffer 1
    send_cmd(8'h90);
    wr(A_BUF, 16'h0061); do_op(16'h0010);
    for (int i = 0; i < ID_LEN; i++) begin
      rd(7'(64 + 8 + i), v); check("R6 id_byte", v, id_byte(i));
    end
    // R6 status read into buffer 2
    send_cmd(8'h70);
    wr(A_BUF, 16'h0062); do_op(16'h0020);
    rd(7'(64 + 16), v); check("R6 status_byte", v, 8'hE0);

    // R4 / R7 page program from buffers 3 and 6
    for (int b = 3; b <= 6; b += 3) begin
      for (int i = 0; i < PAGE_LEN; i++) wr(7'(64 + b * 8 + i), 16'((b * 31 + i * 3) & 255));
      send_cmd(8'h80); send_addr(8'(b));
      wr(A_BUF, 16'(b));
      chk_ready = 1'b1; p0 = prog_total;
      do_op(16'h0004);
      chk_ready = 1'b0;
      check("R4 prog_count", prog_total, p0 + PAGE_LEN);
      for (int i = 0; i < PAGE_LEN; i++)
        check("R4 prog_byte", prog_mem[i], (b * 31 + i * 3) & 255);
    end

    // R5 / R7 page read sweep over all buffers
    for (int b = 0; b < 8; b++) begin
      send_cmd(8'h00); send_addr(8'(16 + b)); send_cmd(8'h30);
      wr(A_BUF, 16'(b));
      chk_ready = 1'b1;
      do_op(16'h0008);
      chk_ready = 1'b0;
      for (int i = 0; i < PAGE_LEN; i++) begin
        rd(7'(64 + b * 8 + i), v); check("R5 read_byte", v, page_byte(8'(16 + b), i));
      end
    end

    // R10 trigger ignored while busy, active op visible
    send_cmd(8'h00); send_addr(8'h55); send_cmd(8'h30);
    wr(A_BUF, 16'h0004);
    c0 = cmd_cnt;
    wr(A_TRIG, 16'h0008);
    wr(A_TRIG, 16'h0001);
    rd(A_TRIG, v); check("R10 active_code", v, 16'h0008);
    wait_done();
    check("R10 no_extra_cmd", cmd_cnt, c0);
    rd(7'(64 + 32), v); check("R10 read_intact", v, page_byte(8'h55, 0));

    // R1 lowest set bit wins
    a0 = ale_cnt; p0 = prog_total;
    wr(A_ADDR, 16'h0033); do_op(16'h0006);
    check("R1 addr_started", ale_cnt, a0 + 1);
    check("R1 no_prog", prog_total, p0);
    check("R1 addr_value", last_addr, 8'h33);
    c0 = cmd_cnt;
    send_cmd(8'h70);
    wr(A_BUF, 16'h0007); do_op(16'h0030);
    rd(7'(64 + 56), v); check("R1 id_over_status", v, id_byte(0) == 8'hE0 ? 8'h00 : 8'hE0);

    // R8 sticky done, R9 interrupt
    wr(A_CMD, 16'h00FF); wr(A_TRIG, 16'h0001); wait_set();
    check("R9 irq_on_done", irq, 1);
    wr(A_TRIG, 16'h8000);
    rd(A_TRIG, v); check("R8 write_one_keeps", v[15], 1);
    repeat (5) @(negedge clk);
    rd(A_TRIG, v); check("R8 still_set", v[15], 1);
    wr(A_CFG, 16'h0090); check("R9 masked", irq, 0);
    wr(A_CFG, 16'h0080); check("R9 unmasked", irq, 1);
    wr(A_TRIG, 16'h0000);
    rd(A_TRIG, v); check("R8 cleared", v[15], 0);
    check("R9 irq_cleared", irq, 0);

    // R11 soft reset aborts a running read
    send_cmd(8'h00); send_addr(8'h11); send_cmd(8'h30);
    wr(A_TRIG, 16'h0008);
    wr(A_CFG, 16'h00C0);
    rd(A_CFG, v); check("R11 bit_set", v[6], 1);
    n = 0;
    do begin rd(A_CFG, v); n++; end while (v[6] && n < 40);
    check("R11 self_clear", int'(n <= RST_CYC), 1);
    rd(A_TRIG, v); check("R11 aborted", v, 0);
    check("R11 strobes_idle", {fl_we_n, fl_re_n, fl_cle, fl_ale}, 4'b1100);
    repeat (BUSY) @(negedge clk);
    c0 = cmd_cnt;
    send_cmd(8'hFF);
    check("R11 works_after", cmd_cnt, c0 + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule